// File: doc/BRIEF.md
# Auto-Increment Shared Memory Access Port

This block lets a host reach a byte-wide memory that it shares with an attached co-processor, through four byte registers picked by a two-bit select. The host loads a pointer as two bytes, then moves bytes through a single data register. When the step flag is set, each access to the data register moves the pointer forward by one. A run of identical data-register accesses therefore copies a block in or out, and the host never reloads the pointer.

A control/status byte holds the co-processor's run and pass-through flags, the step flag and a host-to-co-processor doorbell. It also holds two event flags that the co-processor raises and the host clears. The co-processor has its own port into the same memory. A heartbeat byte at a fixed location is watched: a flag output shows whether that byte holds 0xFF. The co-processor writes 0xFF there to show it is alive, and the host writes 0 after each check. The memory holds 2^RAM_AW bytes. Pointer bits above RAM_AW alias onto it.

Top module: `shram_port`

## Requirements
- R1: After reset, the pointer bytes and the control byte all read 0x00, and the outputs run_o, bypass_o, doorbell_o, host_int_o and alive_o are low.
- R2: Select 0 is the pointer's low byte and select 1 its high byte. Writing either one replaces only that byte, and reading it returns the current value.
- R3: A host read takes effect in the cycle host_rd is high, and host_rdata shows the value in the following cycle. It holds that value until the next read. A read issued together with host_wr is ignored.
- R4: Select 2 is the data register. A write stores the byte at the current pointer, and a read returns the byte at the pointer as it was before any step. When control bit 1 (step) is 1, each data access adds one to the pointer. When it is 0, the pointer does not move.
- R5: Stepping from 0xFFFF gives 0x0000.
- R6: Select 3 is the control byte. A write sets bit 0 (run), bit 1 (step), bit 6 (pass-through) and bit 7 (doorbell) to the written values. Bits 2 and 3 always read 0.
- R7: A pulse on cp_int0_set sets bit 4, and a pulse on cp_int1_set sets bit 5. A host control write with a 1 in that bit clears it, and a 0 leaves it unchanged. A set in the same cycle as a clear wins. host_int_o is high while either bit is 1.
- R8: cp_irq_ack clears the doorbell bit. If a host control write happens in the same cycle, the written bit 7 is taken instead.
- R9: A control write of exactly 0x87 also sets the pass-through bit.
- R10: The co-processor port writes the memory, and cp_rdata returns the byte at cp_addr one cycle later. If both ports write the same location in one cycle, the host byte is stored.
- R11: alive_o is high exactly when the most recent write to location LIVE_ADDR (from either port) wrote 0xFF.
- R12: run_o, bypass_o and doorbell_o follow control bits 0, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 2 | Register select: 0 pointer low, 1 pointer high, 2 data, 3 control |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid the cycle after host_rd |
| cp_we | input | 1 | Co-processor memory write enable |
| cp_addr | input | RAM_AW | Co-processor memory address |
| cp_wdata | input | 8 | Co-processor write byte |
| cp_rdata | output | 8 | Co-processor read byte |
| cp_int0_set | input | 1 | Raise event flag 0 |
| cp_int1_set | input | 1 | Raise event flag 1 |
| cp_irq_ack | input | 1 | Clear the doorbell |
| run_o | output | 1 | Co-processor run flag |
| bypass_o | output | 1 | Pass-through flag |
| doorbell_o | output | 1 | Host doorbell to co-processor |
| host_int_o | output | 1 | Either event flag set |
| alive_o | output | 1 | Heartbeat byte holds 0xFF |

## Verification
The assertions assume that the host never asserts host_wr and host_rd together on the data register. They also assume that the pointer-load and step strobes inside the block are never active together, which follows from the single select. The stimulus drives exactly one host strobe per operation. Co-processor writes are issued in cycles of their own, except in the directed collision case. The event and acknowledge pulses last one cycle, so every "next cycle" property sees a single cause.

// File: rtl/shram_port_pkg.sv
package shram_port_pkg;
  typedef enum logic [1:0] {
    SEL_PTR_LO = 2'd0,
    SEL_PTR_HI = 2'd1,
    SEL_DATA   = 2'd2,
    SEL_CTRL   = 2'd3
  } port_sel_e;

  localparam int B_RUN    = 0;
  localparam int B_STEP   = 1;
  localparam int B_EV0    = 4;
  localparam int B_EV1    = 5;
  localparam int B_PASS   = 6;
  localparam int B_BELL   = 7;

  localparam logic [7:0] COMPAT_KEY = 8'h87;
endpackage

// File: rtl/shram_ptr.sv
module shram_ptr #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          step,
  input  logic [7:0]    wdata,
  output logic [PW-1:0] ptr
);
  localparam int HI_W = PW - 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (ld_lo) begin
      ptr[7:0] <= wdata;
    end else if (ld_hi) begin
      ptr[PW-1:8] <= wdata[HI_W-1:0];
    end else if (step) begin
      ptr <= ptr + 1'b1;
    end
  end

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_lo, ld_hi, step}));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (step && (&ptr)) |=> (ptr == '0));

  assert_lo_keeps_hi_R2: assert property (@(posedge clk) disable iff (rst)
    ld_lo |=> (ptr[PW-1:8] == $past(ptr[PW-1:8])));
endmodule

// File: rtl/shram_ctrl.sv
module shram_ctrl
  import shram_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       ev0_set,
  input  logic       ev1_set,
  input  logic       bell_ack,
  output logic [7:0] ctrl
);
  logic run_q, step_q, pass_q, bell_q, ev0_q, ev1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      step_q <= 1'b0;
      pass_q <= 1'b0;
      bell_q <= 1'b0;
    end else if (wr) begin
      run_q  <= wdata[B_RUN];
      step_q <= wdata[B_STEP];
      pass_q <= wdata[B_PASS] | (wdata == COMPAT_KEY);
      bell_q <= wdata[B_BELL];
    end else if (bell_ack) begin
      bell_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev0_q <= 1'b0;
      ev1_q <= 1'b0;
    end else begin
      if (ev0_set)                ev0_q <= 1'b1;
      else if (wr && wdata[B_EV0]) ev0_q <= 1'b0;
      if (ev1_set)                ev1_q <= 1'b1;
      else if (wr && wdata[B_EV1]) ev1_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl         = 8'h00;
    ctrl[B_RUN]  = run_q;
    ctrl[B_STEP] = step_q;
    ctrl[B_EV0]  = ev0_q;
    ctrl[B_EV1]  = ev1_q;
    ctrl[B_PASS] = pass_q;
    ctrl[B_BELL] = bell_q;
  end

  assert_run_write_R6: assert property (@(posedge clk) disable iff (rst)
    wr |=> (ctrl[B_RUN] == $past(wdata[B_RUN])));

  assert_ev0_set_R7: assert property (@(posedge clk) disable iff (rst)
    ev0_set |=> ctrl[B_EV0]);

  assert_ev1_set_R7: assert property (@(posedge clk) disable iff (rst)
    ev1_set |=> ctrl[B_EV1]);

  assert_bell_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (bell_ack && !wr) |=> !ctrl[B_BELL]);

  assert_compat_key_R9: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata == COMPAT_KEY) |=> ctrl[B_PASS]);
endmodule

// File: rtl/shram_dpram.sv
module shram_dpram #(
  parameter int DW = 8,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_we) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    if (a_re) a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/shram_port.sv
module shram_port
  import shram_port_pkg::*;
#(
  parameter int                PW       = 16,
  parameter int                RAM_AW   = 11,
  parameter logic [RAM_AW-1:0] LIVE_ADDR = 11'h01F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              cp_we,
  input  logic [RAM_AW-1:0] cp_addr,
  input  logic [7:0]        cp_wdata,
  output logic [7:0]        cp_rdata,
  input  logic              cp_int0_set,
  input  logic              cp_int1_set,
  input  logic              cp_irq_ack,
  output logic              run_o,
  output logic              bypass_o,
  output logic              doorbell_o,
  output logic              host_int_o,
  output logic              alive_o
);
  localparam logic [7:0] ALIVE_VAL = 8'hFF;

  port_sel_e          sel;
  logic               rd_ok;
  logic               wr_lo, wr_hi, wr_data, wr_ctrl, rd_data, step;
  logic [PW-1:0]      ptr;
  logic [7:0]         ctrl;
  logic [RAM_AW-1:0]  ram_idx;
  logic [7:0]         ram_q;
  logic [7:0]         snap_q;
  logic               data_q;
  logic               alive_q;

  assign sel     = port_sel_e'(host_sel);
  assign rd_ok   = host_rd && !host_wr;
  assign wr_lo   = host_wr && (sel == SEL_PTR_LO);
  assign wr_hi   = host_wr && (sel == SEL_PTR_HI);
  assign wr_data = host_wr && (sel == SEL_DATA);
  assign wr_ctrl = host_wr && (sel == SEL_CTRL);
  assign rd_data = rd_ok && (sel == SEL_DATA);
  assign step    = (wr_data || rd_data) && ctrl[B_STEP];
  assign ram_idx = ptr[RAM_AW-1:0];

  shram_ptr #(.PW(PW)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .ld_lo (wr_lo),
    .ld_hi (wr_hi),
    .step  (step),
    .wdata (host_wdata),
    .ptr   (ptr)
  );

  shram_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr       (wr_ctrl),
    .wdata    (host_wdata),
    .ev0_set  (cp_int0_set),
    .ev1_set  (cp_int1_set),
    .bell_ack (cp_irq_ack),
    .ctrl     (ctrl)
  );

  shram_dpram #(.DW(8), .AW(RAM_AW)) u_ram (
    .clk     (clk),
    .a_we    (wr_data),
    .a_re    (rd_data),
    .a_addr  (ram_idx),
    .a_wdata (host_wdata),
    .a_rdata (ram_q),
    .b_we    (cp_we),
    .b_addr  (cp_addr),
    .b_wdata (cp_wdata),
    .b_rdata (cp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= 8'h00;
      data_q <= 1'b0;
    end else if (rd_ok) begin
      data_q <= (sel == SEL_DATA);
      unique case (sel)
        SEL_PTR_LO: snap_q <= ptr[7:0];
        SEL_PTR_HI: snap_q <= ptr[PW-1:8];
        SEL_CTRL:   snap_q <= ctrl;
        default:    snap_q <= snap_q;
      endcase
    end
  end

  assign host_rdata = data_q ? ram_q : snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      alive_q <= 1'b0;
    end else if (wr_data && ram_idx == LIVE_ADDR) begin
      alive_q <= (host_wdata == ALIVE_VAL);
    end else if (cp_we && cp_addr == LIVE_ADDR) begin
      alive_q <= (cp_wdata == ALIVE_VAL);
    end
  end

  assign run_o      = ctrl[B_RUN];
  assign bypass_o   = ctrl[B_PASS];
  assign doorbell_o = ctrl[B_BELL];
  assign host_int_o = ctrl[B_EV0] | ctrl[B_EV1];
  assign alive_o    = alive_q;

  assert_no_rdwr_data_R3: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && host_rd && sel == SEL_DATA));

  assert_hold_no_step_R4: assert property (@(posedge clk) disable iff (rst)
    ((wr_data || rd_data) && !ctrl[B_STEP]) |=> $stable(ptr));

  assert_live_host_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_data && ram_idx == LIVE_ADDR && host_wdata == ALIVE_VAL) |=> alive_o);

  assert_live_cp_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (cp_we && cp_addr == LIVE_ADDR && cp_wdata != ALIVE_VAL && !wr_data) |=> !alive_o);

  assert_int_out_R7: assert property (@(posedge clk) disable iff (rst)
    (cp_int0_set || cp_int1_set) |=> host_int_o);
endmodule

// File: tb/shram_port_test.sv
module shram_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int RAM_AW = 11;
  localparam int DEPTH = 1 << RAM_AW;
  localparam logic [RAM_AW-1:0] LIVE = 11'h01F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] host_sel = '0;
  logic host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic cp_we = 0;
  logic [RAM_AW-1:0] cp_addr = '0;
  logic [7:0] cp_wdata = '0;
  logic [7:0] cp_rdata;
  logic cp_int0_set = 0, cp_int1_set = 0, cp_irq_ack = 0;
  logic run_o, bypass_o, doorbell_o, host_int_o, alive_o;

  int checks = 0;
  int errors = 0;

  logic [7:0]  mem_m [DEPTH];
  logic [15:0] ptr_m;
  logic run_m, step_m, pass_m, bell_m, ev0_m, ev1_m, alive_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  shram_port #(.PW(16), .RAM_AW(RAM_AW), .LIVE_ADDR(LIVE)) uut (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cp_we(cp_we), .cp_addr(cp_addr),
    .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .cp_int0_set(cp_int0_set),
    .cp_int1_set(cp_int1_set), .cp_irq_ack(cp_irq_ack), .run_o(run_o),
    .bypass_o(bypass_o), .doorbell_o(doorbell_o), .host_int_o(host_int_o), .alive_o(alive_o)
  );

  function automatic logic [7:0] ctrl_m();
    return {bell_m, pass_m, ev1_m, ev0_m, 2'b00, step_m, run_m};
  endfunction

  function automatic logic [7:0] expect_read(input logic [1:0] s);
    case (s)
      2'd0: return ptr_m[7:0];
      2'd1: return ptr_m[15:8];
      2'd2: return mem_m[ptr_m[RAM_AW-1:0]];
      default: return ctrl_m();
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check_outs();
    check("R12 run_o", {7'd0, run_o}, {7'd0, run_m});
    check("R12 bypass_o", {7'd0, bypass_o}, {7'd0, pass_m});
    check("R12 doorbell_o", {7'd0, doorbell_o}, {7'd0, bell_m});
    check("R7 host_int_o", {7'd0, host_int_o}, {7'd0, ev0_m | ev1_m});
    check("R11 alive_o", {7'd0, alive_o}, {7'd0, alive_m});
  endtask

  task automatic model_host_write(input logic [1:0] s, input logic [7:0] d,
                                  input logic ev0s, input logic ev1s, input logic ack);
    case (s)
      2'd0: ptr_m[7:0] = d;
      2'd1: ptr_m[15:8] = d;
      2'd2: begin
        mem_m[ptr_m[RAM_AW-1:0]] = d;
        if (ptr_m[RAM_AW-1:0] == LIVE) alive_m = (d == 8'hFF);
        if (step_m) ptr_m = ptr_m + 16'd1;
      end
      default: begin
        run_m = d[0]; step_m = d[1]; bell_m = d[7];
        pass_m = d[6] | (d == 8'h87);
        if (d[4]) ev0_m = 1'b0;
        if (d[5]) ev1_m = 1'b0;
      end
    endcase
    if (ev0s) ev0_m = 1'b1;
    if (ev1s) ev1_m = 1'b1;
    if (ack && s != 2'd3) bell_m = 1'b0;
  endtask

  task automatic host_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    host_sel = s; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    model_host_write(s, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic host_read(input logic [1:0] s, input string tag);
    logic [7:0] exp;
    exp = expect_read(s);
    @(negedge clk);
    host_sel = s; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    if (s == 2'd2 && step_m) ptr_m = ptr_m + 16'd1;
    check(tag, host_rdata, exp);
  endtask

  task automatic cp_write(input logic [RAM_AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    cp_we = 1'b1; cp_addr = a; cp_wdata = d;
    @(negedge clk);
    cp_we = 1'b0;
    mem_m[a] = d;
    if (a == LIVE) alive_m = (d == 8'hFF);
  endtask

  task automatic cp_pulse(input logic e0, input logic e1, input logic ack);
    @(negedge clk);
    cp_int0_set = e0; cp_int1_set = e1; cp_irq_ack = ack;
    @(negedge clk);
    cp_int0_set = 0; cp_int1_set = 0; cp_irq_ack = 0;
    if (e0) ev0_m = 1'b1;
    if (e1) ev1_m = 1'b1;
    if (ack) bell_m = 1'b0;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    host_write(2'd0, p[7:0]);
    host_write(2'd1, p[15:8]);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'h00;
    ptr_m = '0; run_m = 0; step_m = 0; pass_m = 0; bell_m = 0; ev0_m = 0; ev1_m = 0; alive_m = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    host_read(2'd0, "R1 ptr lo after reset");
    host_read(2'd1, "R1 ptr hi after reset");
    host_read(2'd3, "R1 ctrl after reset");
    check_outs();

    // Clear memory through the stepping data path (also R4 bulk write)
    host_write(2'd3, 8'h02);
    set_ptr(16'h0000);
    for (int i = 0; i < DEPTH; i++) host_write(2'd2, 8'h00);
    host_read(2'd0, "R5 ptr lo after full pass");
    host_read(2'd1, "R4 ptr hi after full pass");

    // R2 pointer bytes independent
    set_ptr(16'h1234);
    host_write(2'd0, 8'hAB);
    host_read(2'd1, "R2 hi kept after lo write");
    host_read(2'd0, "R2 lo readback");

    // R4 block write then block read back with stepping
    set_ptr(16'h0100);
    for (int i = 0; i < 8; i++) host_write(2'd2, 8'(8'h40 + i));
    set_ptr(16'h0100);
    for (int i = 0; i < 8; i++) host_read(2'd2, "R4 stepped read");
    host_read(2'd0, "R4 ptr after stepped reads");

    // R4 no step: pointer holds
    host_write(2'd3, 8'h01);
    set_ptr(16'h0102);
    host_read(2'd2, "R4 read no step");
    host_read(2'd2, "R4 repeat read no step");
    host_write(2'd2, 8'h99);
    host_read(2'd2, "R4 write no step");
    host_read(2'd0, "R4 ptr held");

    // R5 wrap
    host_write(2'd3, 8'h02);
    set_ptr(16'hFFFF);
    host_write(2'd2, 8'h5A);
    host_read(2'd0, "R5 wrap lo");
    host_read(2'd1, "R5 wrap hi");

    // R3 read with write ignored, hold value
    set_ptr(16'h0020);
    @(negedge clk);
    host_sel = 2'd0; host_wr = 1; host_rd = 1; host_wdata = 8'h77;
    @(negedge clk);
    host_wr = 0; host_rd = 0;
    model_host_write(2'd0, 8'h77, 0, 0, 0);
    host_read(2'd1, "R3 read before");
    repeat (3) @(negedge clk);
    check("R3 rdata held", host_rdata, 8'h00);
    host_read(2'd0, "R3 lo after combined strobe");

    // R6 reserved bits, control fields
    host_write(2'd3, 8'hCF);
    host_read(2'd3, "R6 ctrl reserved zero");
    check_outs();
    host_write(2'd3, 8'h00);
    host_read(2'd3, "R6 ctrl cleared");

    // R9 compat key
    host_write(2'd3, 8'h87);
    host_read(2'd3, "R9 key sets pass");
    check_outs();
    host_write(2'd3, 8'h83);
    host_read(2'd3, "R9 near key no pass");

    // R7 event flags
    cp_pulse(1, 0, 0);
    host_read(2'd3, "R7 ev0 set");
    check_outs();
    cp_pulse(0, 1, 0);
    host_write(2'd3, 8'h12);
    host_read(2'd3, "R7 ev0 cleared ev1 kept");
    check_outs();
    @(negedge clk);
    host_sel = 2'd3; host_wdata = 8'h22; host_wr = 1; cp_int1_set = 1;
    @(negedge clk);
    host_wr = 0; cp_int1_set = 0;
    model_host_write(2'd3, 8'h22, 0, 1, 0);
    host_read(2'd3, "R7 set wins over clear");
    host_write(2'd3, 8'h32);
    check_outs();

    // R8 doorbell
    host_write(2'd3, 8'h82);
    cp_pulse(0, 0, 1);
    host_read(2'd3, "R8 ack clears bell");
    @(negedge clk);
    host_sel = 2'd3; host_wdata = 8'h82; host_wr = 1; cp_irq_ack = 1;
    @(negedge clk);
    host_wr = 0; cp_irq_ack = 0;
    model_host_write(2'd3, 8'h82, 0, 0, 1);
    host_read(2'd3, "R8 write wins over ack");
    check_outs();

    // R10 co-processor port and collision
    cp_write(11'h300, 8'hC3);
    set_ptr(16'h0300);
    host_read(2'd2, "R10 cp write seen by host");
    set_ptr(16'h0301);
    host_write(2'd2, 8'h3C);
    @(negedge clk);
    cp_addr = 11'h301;
    @(negedge clk);
    check("R10 cp_rdata", cp_rdata, 8'h3C);
    set_ptr(16'h0305);
    @(negedge clk);
    host_sel = 2'd2; host_wdata = 8'hAA; host_wr = 1;
    cp_we = 1; cp_addr = 11'h305; cp_wdata = 8'h55;
    @(negedge clk);
    host_wr = 0; cp_we = 0;
    mem_m[11'h305] = 8'h55;
    model_host_write(2'd2, 8'hAA, 0, 0, 0);
    set_ptr(16'h0305);
    host_read(2'd2, "R10 host wins collision");

    // R11 heartbeat
    cp_write(LIVE, 8'hFF);
    check_outs();
    set_ptr({5'd0, LIVE});
    host_read(2'd2, "R11 heartbeat byte");
    set_ptr({5'd0, LIVE});
    host_write(2'd2, 8'h00);
    check_outs();
    set_ptr(16'hF800 | {5'd0, LIVE});
    cp_write(LIVE, 8'hFF);
    host_write(2'd2, 8'hFE);
    check_outs();

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom % 10;
      case (op)
        0: host_write(2'd0, 8'($urandom));
        1: host_write(2'd1, 8'($urandom) & 8'h07);
        2, 3: host_write(2'd2, 8'($urandom));
        4, 5: host_read(2'd2, "R4 random data read");
        6: host_write(2'd3, 8'($urandom));
        7: host_read(2'($urandom), "R2 random register read");
        8: cp_write(RAM_AW'($urandom), 8'($urandom));
        default: cp_pulse(1'($urandom), 1'($urandom), 1'($urandom));
      endcase
      if (n % 50 == 0) check_outs();
    end
    check_outs();
    finish_run();
  end
endmodule